// File: doc/BRIEF.md
# Bus-Attached Seconds Counter with Match Interrupt

This block keeps time in whole seconds for a system on a slow peripheral bus. A 32768 Hz reference is brought into the bus clock domain and turned into single-cycle ticks. Each tick advances a 15-bit prescaler. When the prescaler wraps, the block emits a one-second event and increments a 32-bit seconds counter. A compare register raises a match event when the counter reaches its value. Both events are latched in a status register that clears when it is read, and a single interrupt line combines them under per-event enables.

For production test, bus writes can stand in for the reference edge, for the bus-clock qualifier that lets a tick be counted, or for both. A coarse four-bit view of the prescaler can be read back. While a test-mode pin is high, the prescaler can also be cleared from the bus. Software sees eight word registers, decoded from a three-bit word index.

Top module: `seconds_rtc`

## Requirements
- R1: The word index selects the register: 0 seconds (read/write), 1 compare value (read/write), 2 status (read only), 3 prescaler view/clear, 4 interrupt enables (read/write), 5 tick-source select (write only), 6 reference strobe (write only), 7 qualifier strobe (write only).
- R2: After reset, every readable register returns 0 and the interrupt output is low.
- R3: A read of index 3 returns prescaler stages 14, 11, 7 and 3 on data bits 3, 2, 1 and 0, with zeros above.
- R4: A write to index 3 with data bit 0 at 0 clears the prescaler, but only while test_mode is high. With data bit 0 at 1, or with test_mode low, the write leaves the prescaler unchanged.
- R5: Each counted tick adds one to the 15-bit prescaler. A counted tick at 0x7FFF wraps it to 0, raises a one-second event and increments the seconds counter.
- R6: A write to index 0 loads the seconds counter with the write data and leaves the prescaler untouched.
- R7: Status bit 0 latches one-second events. Status bit 1 latches the cycle on which the seconds counter becomes equal to the compare value. Both bits hold until a read of index 2 clears them, and writes to index 2 have no effect.
- R8: Enable bit 0 (index 4) gates status bit 0 onto irq, and enable bit 1 gates status bit 1. irq is the OR of the two gated bits.
- R9: Reads of indices 5, 6 and 7 return 0.
- R10: When select bit 0 (index 5) is set, each write to index 6 supplies one reference tick in place of the reference input.
- R11: When select bit 1 is set, each write to index 7 acts as the qualifier in place of bus_clk_en. A reference tick that arrives without a qualifier is held pending, and only one tick can be pending at a time.
- R12: In normal mode, each rising edge of ref_clk, after a two-stage synchroniser, is counted on a cycle where bus_clk_en is high. If bus_clk_en is low, the tick is held pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Asynchronous 32768 Hz reference |
| bus_clk_en | input | 1 | Qualifier that allows a pending tick to be counted |
| test_mode | input | 1 | Allows the prescaler clear write |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_word | input | 3 | Word index (byte offset divided by four) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while bus_en is high |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The bench drives the prescaler to exactly 0x7FFF using strobes, checks that the next tick carries into the seconds counter, and raises status bit 0. A design with an off-by-one wrap would miss that carry or show it one tick early. A compare match that lands one cycle after the carry is checked in the same status read as the second event. A design that cleared status on a write, or that did not make the bits sticky, would return the wrong status word or leave irq high after the read. The prescaler clear is tried with test_mode low and with data bit 0 set; a design that ignored either condition would show an empty tap view. The qualifier-strobe mode is exercised with unmatched reference strobes. A design that queued every tick instead of holding a single pending one would read a larger prescaler.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        RG_SECS   = 3'd0,
        RG_MATCH  = 3'd1,
        RG_STAT   = 3'd2,
        RG_PRESC  = 3'd3,
        RG_CTRL   = 3'd4,
        RG_TSEL   = 3'd5,
        RG_STBREF = 3'd6,
        RG_STBQ   = 3'd7
    } reg_idx_e;

    typedef struct packed {
        logic match_ie;
        logic sec_ie;
    } ctrl_t;

    typedef struct packed {
        logic qual_sub;
        logic ref_sub;
    } tsel_t;

    typedef struct packed {
        logic match_hit;
        logic sec_hit;
    } stat_t;

    // sparse view of prescaler stages 14, 11, 7, 3
    function automatic logic [3:0] tap_view(input logic [31:0] p);
        return {p[14], p[11], p[7], p[3]};
    endfunction

endpackage

// File: rtl/rtc_tick_src.sv
module rtc_tick_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ref_clk,
    input  logic          bus_clk_en,
    input  logic          stb_ref,
    input  logic          stb_qual,
    input  rtc_pkg::tsel_t sel,
    output logic          adv
);
    logic [SYNC_STAGES:0] sh_q;
    logic                 pend_q;
    logic                 ref_edge, ref_tick, qual, want;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SYNC_STAGES-1:0], ref_clk};
    end

    always_comb begin
        ref_edge = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
        ref_tick = sel.ref_sub  ? stb_ref  : ref_edge;
        qual     = sel.qual_sub ? stb_qual : bus_clk_en;
        want     = pend_q | ref_tick;
        adv      = want & qual;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= want & ~qual;
    end
endmodule

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int PRESC_W = 15,
    parameter int SEC_W   = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic               presc_clr,
    input  logic               sec_we,
    input  logic [SEC_W-1:0]   sec_wdata,
    input  logic [SEC_W-1:0]   match_val,
    output logic [PRESC_W-1:0] presc,
    output logic [SEC_W-1:0]   seconds,
    output logic               sec_evt,
    output logic               match_evt
);
    localparam logic [PRESC_W-1:0] PRESC_TOP = '1;

    logic eq, eq_q;

    always_comb begin
        sec_evt   = adv && (presc == PRESC_TOP);
        eq        = (seconds == match_val);
        match_evt = eq && !eq_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            presc   <= '0;
            seconds <= '0;
            eq_q    <= 1'b1;
        end else begin
            if (presc_clr)  presc <= '0;
            else if (adv)   presc <= presc + 1'b1;
            if (sec_we)       seconds <= sec_wdata;
            else if (sec_evt) seconds <= seconds + 1'b1;
            eq_q <= eq;
        end
    end
endmodule

// File: rtl/seconds_rtc.sv
module seconds_rtc #(
    parameter int DATA_W      = 32,
    parameter int SEC_W       = 32,
    parameter int PRESC_W     = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_clk,
    input  logic              bus_clk_en,
    input  logic              test_mode,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [2:0]        bus_word,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    import rtc_pkg::*;

    reg_idx_e           idx;
    logic               wr, rd;
    logic [SEC_W-1:0]   match_q;
    ctrl_t              ctrl_q;
    tsel_t              tsel_q;
    stat_t              stat_q;
    logic               adv, presc_clr, sec_evt, match_evt;
    logic [PRESC_W-1:0] presc_q;
    logic [SEC_W-1:0]   secs_q;
    logic [31:0]        presc_zx;

    always_comb begin
        idx       = reg_idx_e'(bus_word);
        wr        = bus_en && bus_wr;
        rd        = bus_en && !bus_wr;
        presc_clr = wr && (idx == RG_PRESC) && test_mode && !bus_wdata[0];
    end

    rtc_tick_src #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk        (clk),
        .rst        (rst),
        .ref_clk    (ref_clk),
        .bus_clk_en (bus_clk_en),
        .stb_ref    (wr && idx == RG_STBREF),
        .stb_qual   (wr && idx == RG_STBQ),
        .sel        (tsel_q),
        .adv        (adv)
    );

    rtc_timebase #(.PRESC_W(PRESC_W), .SEC_W(SEC_W)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .presc_clr (presc_clr),
        .sec_we    (wr && idx == RG_SECS),
        .sec_wdata (bus_wdata[SEC_W-1:0]),
        .match_val (match_q),
        .presc     (presc_q),
        .seconds   (secs_q),
        .sec_evt   (sec_evt),
        .match_evt (match_evt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            ctrl_q  <= '0;
            tsel_q  <= '0;
            stat_q  <= '0;
        end else begin
            if (wr && idx == RG_MATCH) match_q <= bus_wdata[SEC_W-1:0];
            if (wr && idx == RG_CTRL)  ctrl_q  <= ctrl_t'(bus_wdata[1:0]);
            if (wr && idx == RG_TSEL)  tsel_q  <= tsel_t'(bus_wdata[1:0]);
            stat_q.sec_hit   <= sec_evt   || (stat_q.sec_hit   && !(rd && idx == RG_STAT));
            stat_q.match_hit <= match_evt || (stat_q.match_hit && !(rd && idx == RG_STAT));
        end
    end

    always_comb begin
        presc_zx = '0;
        presc_zx[PRESC_W-1:0] = presc_q;
        bus_rdata = '0;
        if (rd) begin
            case (idx)
                RG_SECS:  bus_rdata[SEC_W-1:0] = secs_q;
                RG_MATCH: bus_rdata[SEC_W-1:0] = match_q;
                RG_STAT:  bus_rdata[1:0]       = stat_q;
                RG_PRESC: bus_rdata[3:0]       = tap_view(presc_zx);
                RG_CTRL:  bus_rdata[1:0]       = ctrl_q;
                default:  bus_rdata            = '0;
            endcase
        end
        irq = (stat_q.sec_hit && ctrl_q.sec_ie) || (stat_q.match_hit && ctrl_q.match_ie);
    end
endmodule

// File: rtl/rtc_props.sv
module rtc_props #(
    parameter int DATA_W  = 32,
    parameter int SEC_W   = 32,
    parameter int PRESC_W = 15
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_en,
    input logic               bus_wr,
    input logic [2:0]         bus_word,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               test_mode,
    input logic               irq,
    input logic [PRESC_W-1:0] presc,
    input logic [SEC_W-1:0]   seconds,
    input logic               sec_evt,
    input logic               match_evt,
    input logic [1:0]         status
);
    localparam logic [PRESC_W-1:0] P_ONE = 1;
    localparam logic [SEC_W-1:0]   S_ONE = 1;

    // R9
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_wr && bus_word >= 3'd5) |-> (bus_rdata == '0));

    // R4
    presc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr && bus_word == 3'd3 && !test_mode) |=>
        (presc == $past(presc) || presc == $past(presc) + P_ONE));

    // R6
    sec_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && bus_wr && bus_word == 3'd0) |=> (seconds == $past(bus_wdata[SEC_W-1:0])));

    // R5
    sec_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_evt && !(bus_en && bus_wr && bus_word == 3'd0)) |=> (seconds == $past(seconds) + S_ONE));

    // R7
    stat_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (status[0] && !(bus_en && !bus_wr && bus_word == 3'd2)) |=> status[0]);

    // R8
    irq_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_wr && bus_word == 3'd2 && !sec_evt && !match_evt) |=> !irq);
endmodule

bind seconds_rtc rtc_props #(.DATA_W(DATA_W), .SEC_W(SEC_W), .PRESC_W(PRESC_W)) u_props (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .test_mode (test_mode),
    .irq       (irq),
    .presc     (presc_q),
    .seconds   (secs_q),
    .sec_evt   (sec_evt),
    .match_evt (match_evt),
    .status    (stat_q)
);

// File: tb/seconds_rtc_test.sv
module seconds_rtc_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_clk = 1'b0;
    logic        bus_clk_en = 1'b1;
    logic        test_mode = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_word = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    seconds_rtc uut (
        .clk(clk), .rst(rst), .ref_clk(ref_clk), .bus_clk_en(bus_clk_en),
        .test_mode(test_mode), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // monitor: compare read data away from the active edge
    always @(negedge clk) begin
        if (bus_en && !bus_wr && sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (bus_rdata !== it.exp) begin
                errors++;
                $display("FAIL %s: got %h expected %h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] w, input logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] w, input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        bus_en = 1'b1; bus_wr = 1'b0; bus_word = w;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        checks++;
        if (irq !== e) begin
            errors++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, e);
        end
    endtask

    task automatic strobes(input int n);
        repeat (n) wr(3'd6, 32'h0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R2 reset state
        chk_irq(1'b0, "R2 reset irq");
        for (int i = 0; i < 8; i++) rd(3'(i), 32'h0, "R2 reset read");

        // R1 register placement
        wr(3'd0, 32'h1000_0005);
        wr(3'd1, 32'hFFFF_0000);
        rd(3'd0, 32'h1000_0005, "R1 seconds readback");
        rd(3'd1, 32'hFFFF_0000, "R1 compare readback");

        // R9 write-only locations read zero
        wr(3'd5, 32'h1);
        rd(3'd5, 32'h0, "R9 select reads zero");

        // R10 + R3: strobes replace reference; taps 14,11,7,3
        strobes(32'h0888);
        rd(3'd3, 32'h7, "R3 tap view of 0x0888");
        rd(3'd6, 32'h0, "R9 strobe reads zero");

        // R6 seconds load keeps prescaler
        wr(3'd0, 32'h1000_0006);
        rd(3'd3, 32'h7, "R6 prescaler kept");
        rd(3'd0, 32'h1000_0006, "R6 seconds loaded");

        // R4 clear gating
        wr(3'd3, 32'h0);
        rd(3'd3, 32'h7, "R4 clear blocked without test_mode");
        test_mode = 1'b1;
        wr(3'd3, 32'h1);
        rd(3'd3, 32'h7, "R4 bit0 set does not clear");
        wr(3'd3, 32'h0);
        rd(3'd3, 32'h0, "R4 clear in test mode");
        test_mode = 1'b0;

        // R8 enable readback
        wr(3'd4, 32'h1);
        rd(3'd4, 32'h1, "R8 enable readback");

        // R5 wrap at 0x7FFF
        strobes(32767);
        rd(3'd3, 32'hF, "R5 prescaler at top");
        chk_irq(1'b0, "R5 no event before wrap");
        rd(3'd0, 32'h1000_0006, "R5 seconds before wrap");
        strobes(1);
        rd(3'd0, 32'h1000_0007, "R5 seconds incremented");
        rd(3'd3, 32'h0, "R5 prescaler wrapped");
        // R7 writes to status ignored
        wr(3'd2, 32'h0);
        chk_irq(1'b1, "R8 irq on second event");
        rd(3'd2, 32'h1, "R7 second bit sticky after write");
        chk_irq(1'b0, "R8 irq cleared by read");
        rd(3'd2, 32'h0, "R7 cleared on read");

        // R7 match event with only match enabled
        wr(3'd1, 32'h1000_0008);
        wr(3'd4, 32'h2);
        strobes(32767);
        chk_irq(1'b0, "R8 no irq before match");
        strobes(1);
        idle(2);
        chk_irq(1'b1, "R8 irq on match");
        rd(3'd2, 32'h3, "R7 both events latched");
        chk_irq(1'b0, "R8 irq cleared after match read");

        // R11 qualifier strobe mode, single pending tick
        wr(3'd5, 32'h3);
        strobes(8);
        rd(3'd3, 32'h0, "R11 no count without qualifier");
        wr(3'd7, 32'h0);
        for (int i = 0; i < 7; i++) begin
            wr(3'd6, 32'h0);
            wr(3'd7, 32'h0);
        end
        rd(3'd3, 32'h1, "R11 eight qualified ticks");

        // R12 real reference path
        wr(3'd5, 32'h0);
        test_mode = 1'b1;
        wr(3'd3, 32'h0);
        test_mode = 1'b0;
        for (int i = 0; i < 8; i++) begin
            ref_clk = 1'b1; idle(10);
            ref_clk = 1'b0; idle(10);
        end
        rd(3'd3, 32'h1, "R12 eight reference edges");
        bus_clk_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            ref_clk = 1'b1; idle(10);
            ref_clk = 1'b0; idle(10);
        end
        rd(3'd3, 32'h1, "R12 held without qualifier");

        idle(3);
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule